// File: doc/BRIEF.md
# Flash Bus Operation Decoder

This block is the synchronous pin front end of a parallel NOR-style flash model. On every rising clock edge it captures the active-low chip enable, output enable, write enable and hardware-reset pins. It also captures a width-select pin, a boot-protect pin, the word address and the incoming data bus. From the captured pins it names the bus operation for that cycle. It drives per-pin output enables and read data, and it issues lane write strobes into a small internal word array.

The width-select pin picks full-width words or single bytes. In byte operation only the low half of the data bus carries data. The top data pin then stops being data and becomes the address bit below bit 0, which picks the byte lane. The boot-protect pin, when low, locks the two outermost sectors at each end of the array against writes. The array holds 64 words in 8 sectors of 8 words each, and the sector number is `addr[5:3]`.

All outputs follow the pins captured at the most recent rising edge. A write takes effect in the array at the edge after the one that captured it.

Top module: `flash_bus_front`

## Requirements
- R1: While `rst_n` is low, `op` reads standby (code 0) and `dq_oe` is all zero, whatever the pins do.
- R2: A read is `hw_rst_n`=1, `ce_n`=0, `oe_n`=0 and `we_n`=1. With `wide_sel`=1 (word operation), `op` is 1, `dq_oe` is 16'hFFFF and `dq_out` is the stored word at `addr`.
- R3: A read with `wide_sel`=0 (byte operation) gives `dq_oe`=16'h00FF. `dq_out[7:0]` is the low byte of the word when `dq_in[15]`=0 and the high byte when it is 1. `dq_out[15:8]` is 0.
- R4: With `hw_rst_n`=0, `op` is 4, `dq_oe` is zero and nothing is written, whatever the other pins do. The first read after it returns array data with no command in between.
- R5: With `hw_rst_n`=1 and `ce_n`=1, `op` is standby (0), `dq_oe` is zero and nothing is written.
- R6: `ce_n`=0 with `oe_n`=1 and `we_n`=1 gives output disable: `op` is 3 and `dq_oe` is zero.
- R7: A write is `ce_n`=0, `we_n`=0 and `oe_n`=1. It gives `op`=2 and `dq_oe`=0. In word operation, `dq_in` is stored at `addr`.
- R8: A byte-operation write stores `dq_in[7:0]` into the lane picked by `dq_in[15]` (0 low, 1 high) and leaves the other lane unchanged.
- R9: `ce_n`=0 with both `oe_n` and `we_n` low is treated as output disable: `op` is 3, `dq_oe` is zero and nothing is written.
- R10: With `wprot_n`=0, writes to sectors 0, 1, 6 and 7 (`addr[5:3]`) leave the array unchanged. Sectors 2 to 5 stay writable, and with `wprot_n`=1 every sector is writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| hw_rst_n | input | 1 | Active-low hardware-reset pin |
| ce_n | input | 1 | Active-low chip enable pin |
| oe_n | input | 1 | Active-low output enable pin |
| we_n | input | 1 | Active-low write enable pin |
| wide_sel | input | 1 | 1 selects word operation, 0 selects byte operation |
| wprot_n | input | 1 | Active-low boot-sector protect pin |
| addr | input | 6 | Word address |
| dq_in | input | 16 | Data bus input; bit 15 is the lane address in byte operation |
| dq_out | output | 16 | Data bus output value |
| dq_oe | output | 16 | Per-pin output enable |
| op | output | 3 | Decoded operation: 0 standby, 1 read, 2 write, 3 output disable, 4 reset |

## Verification
The assertions assume every pin is held steady across each rising edge. They also assume the pins seen at one edge decide the outputs until the next edge, so each check compares outputs with pin values one cycle old. The checker only looks back once a full sampled cycle has passed since `rst_n` was released. The stimulus changes pins only on falling edges. During reset it keeps a read pattern on the pins, so the standby check means something. Every control-pin combination is swept in both widths and with protection both on and off.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;

  typedef enum logic [2:0] {
    OP_STANDBY = 3'd0,
    OP_READ    = 3'd1,
    OP_WRITE   = 3'd2,
    OP_OUTDIS  = 3'd3,
    OP_RESET   = 3'd4
  } bus_op_e;

  typedef struct packed {
    logic hw_rst_n;
    logic ce_n;
    logic oe_n;
    logic we_n;
    logic wide_sel;
    logic wprot_n;
  } ctl_pins_t;

  localparam ctl_pins_t CTL_IDLE = '{hw_rst_n: 1'b1, ce_n: 1'b1, oe_n: 1'b1,
                                     we_n: 1'b1, wide_sel: 1'b1, wprot_n: 1'b1};

endpackage

// File: rtl/fbd_pin_sampler.sv
module fbd_pin_sampler
  import flash_bus_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_en,
  input  ctl_pins_t         ctl_in,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] din_in,
  output ctl_pins_t         ctl_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] din_q
);

  ctl_pins_t         ctl_d;
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] din_d;

  always_comb begin
    ctl_d  = ctl_q;
    addr_d = addr_q;
    din_d  = din_q;
    if (smp_en) begin
      ctl_d  = ctl_in;
      addr_d = addr_in;
      din_d  = din_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= CTL_IDLE;
      addr_q <= '0;
      din_q  <= '0;
    end else begin
      ctl_q  <= ctl_d;
      addr_q <= addr_d;
      din_q  <= din_d;
    end
  end

endmodule

// File: rtl/fbd_op_decode.sv
module fbd_op_decode
  import flash_bus_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int SECT_W    = 3,
  parameter int DATA_W    = 16,
  parameter int BOOT_SECT = 2
) (
  input  ctl_pins_t         ctl_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] din_q,
  output bus_op_e           op,
  output logic [DATA_W-1:0] pin_oe,
  output logic              lane_hi,
  output logic [1:0]        wr_lane,
  output logic [DATA_W-1:0] wr_data
);

  localparam int HALF  = DATA_W / 2;
  localparam int NSECT = 1 << SECT_W;

  logic [SECT_W-1:0] sector;
  logic              in_boot;
  logic              write_ok;

  assign sector  = addr_q[ADDR_W-1 -: SECT_W];
  assign in_boot = (int'(sector) < BOOT_SECT) || (int'(sector) >= NSECT - BOOT_SECT);

  always_comb begin
    if (!ctl_q.hw_rst_n)                op = OP_RESET;
    else if (ctl_q.ce_n)                op = OP_STANDBY;
    else if (!ctl_q.oe_n && ctl_q.we_n) op = OP_READ;
    else if (ctl_q.oe_n && !ctl_q.we_n) op = OP_WRITE;
    else                                op = OP_OUTDIS;
  end

  always_comb begin
    pin_oe = '0;
    if (op == OP_READ) begin
      pin_oe = ctl_q.wide_sel ? {DATA_W{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
    end
  end

  assign lane_hi  = !ctl_q.wide_sel && din_q[DATA_W-1];
  assign write_ok = (op == OP_WRITE) && !(in_boot && !ctl_q.wprot_n);

  always_comb begin
    wr_lane = 2'b00;
    if (write_ok) begin
      if (ctl_q.wide_sel) wr_lane = 2'b11;
      else                wr_lane = lane_hi ? 2'b10 : 2'b01;
    end
  end

  assign wr_data = ctl_q.wide_sel ? din_q : {din_q[HALF-1:0], din_q[HALF-1:0]};

endmodule

// File: rtl/fbd_word_array.sv
module fbd_word_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic [1:0]        wr_lane,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);

  localparam int HALF  = DATA_W / 2;
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [HALF-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_lane[g]) begin
        cells[addr] <= wr_data[g*HALF +: HALF];
      end
    end

    assign rd_data[g*HALF +: HALF] = cells[addr];
  end

endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
  import flash_bus_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int SECT_W    = 3,
  parameter int DATA_W    = 16,
  parameter int BOOT_SECT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              wide_sel,
  input  logic              wprot_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] dq_oe,
  output logic [2:0]        op
);

  localparam int HALF = DATA_W / 2;

  ctl_pins_t         ctl_in, ctl_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q;
  bus_op_e           op_dec;
  logic              lane_hi;
  logic [1:0]        wr_lane;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;

  assign ctl_in = '{hw_rst_n: hw_rst_n, ce_n: ce_n, oe_n: oe_n,
                    we_n: we_n, wide_sel: wide_sel, wprot_n: wprot_n};

  fbd_pin_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
    .clk    (clk),
    .rst_n  (rst_n),
    .smp_en (1'b1),
    .ctl_in (ctl_in),
    .addr_in(addr),
    .din_in (dq_in),
    .ctl_q  (ctl_q),
    .addr_q (addr_q),
    .din_q  (din_q)
  );

  fbd_op_decode #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .DATA_W(DATA_W),
                  .BOOT_SECT(BOOT_SECT)) u_dec (
    .ctl_q  (ctl_q),
    .addr_q (addr_q),
    .din_q  (din_q),
    .op     (op_dec),
    .pin_oe (dq_oe),
    .lane_hi(lane_hi),
    .wr_lane(wr_lane),
    .wr_data(wr_data)
  );

  fbd_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
    .clk    (clk),
    .wr_lane(wr_lane),
    .addr   (addr_q),
    .wr_data(wr_data),
    .rd_data(rd_data)
  );

  always_comb begin
    dq_out = '0;
    if (op_dec == OP_READ) begin
      if (ctl_q.wide_sel) dq_out = rd_data;
      else dq_out = {{HALF{1'b0}}, (lane_hi ? rd_data[DATA_W-1 -: HALF] : rd_data[HALF-1:0])};
    end
  end

  assign op = op_dec;

endmodule

// File: rtl/fbd_checker.sv
module fbd_checker #(
  parameter int ADDR_W    = 6,
  parameter int SECT_W    = 3,
  parameter int DATA_W    = 16,
  parameter int BOOT_SECT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hw_rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              wide_sel,
  input logic              wprot_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dq_oe,
  input logic [2:0]        op,
  input logic [1:0]        wr_lane
);

  localparam int NSECT = 1 << SECT_W;
  localparam int HALF  = DATA_W / 2;

  logic              primed;
  logic [ADDR_W-1:0] addr_d;
  logic              wprot_d;
  logic [SECT_W-1:0] sect_d;
  logic              boot_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed  <= 1'b0;
      addr_d  <= '0;
      wprot_d <= 1'b1;
    end else begin
      primed  <= 1'b1;
      addr_d  <= addr;
      wprot_d <= wprot_n;
    end
  end

  assign sect_d = addr_d[ADDR_W-1 -: SECT_W];
  assign boot_d = (int'(sect_d) < BOOT_SECT) || (int'(sect_d) >= NSECT - BOOT_SECT);

  a_r4_reset_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    primed && !$past(hw_rst_n) |-> (op == 3'd4) && (dq_oe == '0) && (wr_lane == 2'b00));

  a_r5_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(hw_rst_n && ce_n) |-> (op == 3'd0) && (dq_oe == '0) && (wr_lane == 2'b00));

  // R6 and R9: both strobes equal means output disable
  a_r9_outdis_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(hw_rst_n && !ce_n && (oe_n == we_n)) |-> (op == 3'd3) && (dq_oe == '0) && (wr_lane == 2'b00));

  a_r2_word_read_drive: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(hw_rst_n && !ce_n && !oe_n && we_n && wide_sel) |-> (op == 3'd1) && (&dq_oe));

  a_r3_byte_upper_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(!wide_sel) |-> (dq_oe[DATA_W-1:HALF] == '0));

  a_r8_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(!wide_sel) |-> ($countones(wr_lane) <= 1));

  a_r10_boot_locked: assert property (@(posedge clk) disable iff (!rst_n)
    primed && !wprot_d && boot_d |-> (wr_lane == 2'b00));

  a_r7_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    primed && (wr_lane != 2'b00) |-> (op == 3'd2) && (dq_oe == '0));

endmodule

bind flash_bus_front fbd_checker #(
  .ADDR_W(ADDR_W), .SECT_W(SECT_W), .DATA_W(DATA_W), .BOOT_SECT(BOOT_SECT)
) u_fbd_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .hw_rst_n(hw_rst_n),
  .ce_n    (ce_n),
  .oe_n    (oe_n),
  .we_n    (we_n),
  .wide_sel(wide_sel),
  .wprot_n (wprot_n),
  .addr    (addr),
  .dq_oe   (dq_oe),
  .op      (op),
  .wr_lane (wr_lane)
);

// File: tb/test_flash_bus_front.sv
module test_flash_bus_front;

  logic        clk;
  logic        rst_n;
  logic        hw_rst_n, ce_n, oe_n, we_n, wide_sel, wprot_n;
  logic [5:0]  addr;
  logic [15:0] dq_in;
  logic [15:0] dq_out;
  logic [15:0] dq_oe;
  logic [2:0]  op;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [2:0]  op;
    logic [15:0] oe;
    logic [15:0] dout;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [15:0] model [64];

  flash_bus_front i_flash_bus_front (
    .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .wide_sel(wide_sel), .wprot_n(wprot_n), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .op(op)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [2:0] a_op, input logic [15:0] a_oe,
                       input logic [15:0] a_do, input exp_t e);
    checks++;
    if (a_op !== e.op || a_oe !== e.oe || a_do !== e.dout) begin
      errors++;
      $display("FAIL %s: op=%0d oe=%h dout=%h expected op=%0d oe=%h dout=%h",
               tag, a_op, a_oe, a_do, e.op, e.oe, e.dout);
    end
  endtask

  // driver: applies one bus cycle and pushes the expected outcome
  task automatic drive(input bit hw, input bit ce, input bit oe, input bit we, input bit wide,
                       input bit wp, input logic [5:0] a, input logic [15:0] d, input string tag);
    exp_t e;
    bit   boot;
    bit   hi;
    @(negedge clk);
    hw_rst_n = hw; ce_n = ce; oe_n = oe; we_n = we; wide_sel = wide; wprot_n = wp;
    addr = a; dq_in = d;
    e.oe = 16'h0000; e.dout = 16'h0000;
    boot = (a[5:3] <= 3'd1) || (a[5:3] >= 3'd6);
    hi = d[15];
    if (!hw) begin
      e.op = 3'd4; e.tag = "R4";
    end else if (ce) begin
      e.op = 3'd0; e.tag = "R5";
    end else if (!oe && we) begin
      e.op = 3'd1;
      if (wide) begin
        e.oe = 16'hFFFF; e.dout = model[a]; e.tag = "R2";
      end else begin
        e.oe = 16'h00FF; e.dout = {8'h00, hi ? model[a][15:8] : model[a][7:0]}; e.tag = "R3";
      end
    end else if (oe && !we) begin
      e.op = 3'd2;
      e.tag = wide ? "R7" : "R8";
      if (!(boot && !wp)) begin
        if (wide) model[a] = d;
        else if (hi) model[a][15:8] = d[7:0];
        else model[a][7:0] = d[7:0];
      end
    end else begin
      e.op = 3'd3;
      e.tag = (!oe && !we) ? "R9" : "R6";
    end
    if (tag != "") e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic rd_word(input logic [5:0] a, input string tag);
    drive(1, 0, 0, 1, 1, 1, a, 16'h0000, tag);
  endtask

  // monitor: compares outputs just after each edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, op, dq_oe, dq_out, e);
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    hw_rst_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; wide_sel = 1'b1; wprot_n = 1'b1;
    addr = 6'd5; dq_in = 16'h0000;
    for (int i = 0; i < 64; i++) model[i] = 16'h0000;
    repeat (3) @(negedge clk);
    begin
      exp_t e0;
      e0.op = 3'd0; e0.oe = 16'h0000; e0.dout = 16'h0000; e0.tag = "R1";
      check("R1", op, dq_oe, dq_out, e0);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // fill the whole array unprotected (R7)
    for (int i = 0; i < 64; i++) begin
      drive(1, 0, 1, 0, 1, 1, 6'(i), 16'hA000 ^ 16'(i * 16'h0137), "R7");
    end
    for (int i = 0; i < 64; i += 9) rd_word(6'(i), "R7");

    // every control combination, both widths, both protect levels
    for (int wp = 0; wp < 2; wp++) begin
      for (int c = 0; c < 32; c++) begin
        for (int k = 0; k < 4; k++) begin
          logic [5:0] a;
          a = (k == 0) ? 6'd0 : (k == 1) ? 6'd19 : (k == 2) ? 6'd42 : 6'd63;
          drive(c[4], c[3], c[2], c[1], c[0], wp[0], a,
                16'h5A00 ^ 16'(c * 16'h0111 + k * 16'h8013), "");
          rd_word(a, "");
        end
      end
    end

    // byte lanes: write each lane, read both lanes and the whole word (R3, R8)
    drive(1, 0, 1, 0, 1, 1, 6'd20, 16'h1234, "R7");
    drive(1, 0, 1, 0, 0, 1, 6'd20, 16'h00CD, "R8");
    rd_word(6'd20, "R8");
    drive(1, 0, 1, 0, 0, 1, 6'd20, 16'h80EF, "R8");
    rd_word(6'd20, "R8");
    drive(1, 0, 0, 1, 0, 1, 6'd20, 16'h0000, "R3");
    drive(1, 0, 0, 1, 0, 1, 6'd20, 16'h8000, "R3");

    // boot protect (R10): locked ends, open middle, release
    for (int s = 0; s < 8; s++) begin
      drive(1, 0, 1, 0, 1, 0, 6'(s * 8 + 3), 16'hBEEF, "R10");
      rd_word(6'(s * 8 + 3), "R10");
      drive(1, 0, 1, 0, 0, 0, 6'(s * 8 + 4), 16'h8077, "R10");
      rd_word(6'(s * 8 + 4), "R10");
    end
    drive(1, 0, 1, 0, 1, 1, 6'd57, 16'hC0DE, "R10");
    rd_word(6'd57, "R10");

    // collision and hardware reset pin leave data alone (R9, R4)
    drive(1, 0, 0, 0, 1, 1, 6'd33, 16'hDEAD, "R9");
    rd_word(6'd33, "R9");
    drive(0, 0, 1, 0, 1, 1, 6'd34, 16'hFACE, "R4");
    drive(0, 0, 0, 1, 1, 1, 6'd34, 16'h0000, "R4");
    rd_word(6'd34, "R4");
    drive(1, 0, 1, 1, 1, 1, 6'd34, 16'h0000, "R6");

    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule